// File: doc/BRIEF.md
# Two-Level One-Hot Address Decoder

This block turns a binary address into a one-hot select word. With the default parameters it takes a 6-bit address and an enable and drives 64 select lines. At most one line is high, and that line is the one whose index equals the address.

The decoder is not written as one flat comparison bank. It is built from a small enabled decoder cell that is used twice over. A root cell decodes the upper address bits into group enables. Each group enable drives one leaf cell, and every leaf cell decodes the lower address bits into its own slice of eight outputs. When the external enable is low, the root cell is idle, so every leaf cell is idle and all outputs are low.

The widths of the root and leaf cells are separate parameters. Setting the root width to 1 with 3-bit leaves gives a 4-to-16 decoder made of two 8-output cells. The block has no clock and no storage: its outputs follow its inputs directly.

Top module: `onehot_tree_dec`

## Requirements
- R1: When `en` is 1, output bit `dec_out[addr]` is 1.
- R2: At most one bit of `dec_out` is 1 at any time. Exactly one bit is 1 when `en` is 1.
- R3: When `en` is 0, all bits of `dec_out` are 0 for every address.
- R4: The outputs form groups of eight. Group g is bits 8g to 8g+7 and is selected by `addr[5:3]` = g. Within the group, `addr[2:0]` picks the bit. With `en` at 1, only the selected group holds a set bit.
- R5: For all 128 combinations of `en` and `addr`, `dec_out` equals `en` shifted left by `addr`.
- R6: With ROOT_W = 1 and LEAF_W = 3 the block is a 4-to-16 decoder. In that setting `addr[3]` selects which of the two 8-output cells is enabled, and the same shift law holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| en | input | 1 | Global enable; 0 forces all outputs low |
| addr | input | ROOT_W+LEAF_W (6) | Binary address; the upper ROOT_W bits pick the group, the lower LEAF_W bits pick the line |
| dec_out | output | 2^(ROOT_W+LEAF_W) (64) | One-hot select lines |

## Verification
Every result is due in the same cycle as its stimulus, because no register lies between `addr`/`en` and `dec_out`. The bench changes the inputs on the falling clock edge and samples the outputs one nanosecond later, well before the next rising edge. This way each check sees settled combinational outputs and never a value from the previous stimulus. The bound checker re-evaluates its properties whenever the inputs or outputs change.

// File: rtl/onehot_leaf_dec.sv
module onehot_leaf_dec #(
  parameter int W = 3,
  localparam int N = 1 << W
) (
  input  logic         en,
  input  logic [W-1:0] sel,
  output logic [N-1:0] y
);

  for (genvar i = 0; i < N; i++) begin : g_line
    assign y[i] = en && (sel == W'(i));
  end

endmodule

// File: rtl/onehot_tree_dec.sv
module onehot_tree_dec #(
  parameter int ROOT_W = 3,
  parameter int LEAF_W = 3,
  localparam int ADDR_W = ROOT_W + LEAF_W,
  localparam int OUT_W  = 1 << ADDR_W
) (
  input  logic              en,
  input  logic [ADDR_W-1:0] addr,
  output logic [OUT_W-1:0]  dec_out
);

  localparam int GROUPS = 1 << ROOT_W;
  localparam int LEAF_N = 1 << LEAF_W;

  logic [GROUPS-1:0] grp_en;

  onehot_leaf_dec #(.W(ROOT_W)) u_root (
    .en  (en),
    .sel (addr[ADDR_W-1:LEAF_W]),
    .y   (grp_en)
  );

  for (genvar g = 0; g < GROUPS; g++) begin : g_leaf
    onehot_leaf_dec #(.W(LEAF_W)) u_leaf (
      .en  (grp_en[g]),
      .sel (addr[LEAF_W-1:0]),
      .y   (dec_out[g*LEAF_N +: LEAF_N])
    );
  end

endmodule

// File: rtl/onehot_tree_dec_chk.sv
module onehot_tree_dec_chk #(
  parameter int ROOT_W = 3,
  parameter int LEAF_W = 3,
  localparam int ADDR_W = ROOT_W + LEAF_W,
  localparam int OUT_W  = 1 << ADDR_W,
  localparam int LEAF_N = 1 << LEAF_W
) (
  input logic              en,
  input logic [ADDR_W-1:0] addr,
  input logic [OUT_W-1:0]  dec_out
);

  logic [LEAF_N-1:0] sel_grp;
  assign sel_grp = dec_out[addr[ADDR_W-1:LEAF_W]*LEAF_N +: LEAF_N];

  always_comb begin
    p_addr_line_r1: assert (!en || dec_out[addr])
      else $error("R1: addressed line low while enabled");
    p_onehot_r2: assert ($onehot0(dec_out))
      else $error("R2: more than one line high");
    p_count_r2: assert ($countones(dec_out) == (en ? 1 : 0))
      else $error("R2: active line count wrong");
    p_idle_r3: assert (en || dec_out == '0)
      else $error("R3: line high while disabled");
    p_group_r4: assert ((sel_grp != '0) == en)
      else $error("R4: addressed group activity mismatch");
  end

endmodule

bind onehot_tree_dec onehot_tree_dec_chk #(.ROOT_W(ROOT_W), .LEAF_W(LEAF_W)) u_chk (
  .en      (en),
  .addr    (addr),
  .dec_out (dec_out)
);

// File: tb/sim_onehot_tree_dec.sv
module sim_onehot_tree_dec;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        en0 = 1'b0;
  logic [5:0]  addr0 = '0;
  logic [63:0] out0;
  logic        en1 = 1'b0;
  logic [3:0]  addr1 = '0;
  logic [15:0] out1;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  onehot_tree_dec u0 (.en(en0), .addr(addr0), .dec_out(out0));
  onehot_tree_dec #(.ROOT_W(1), .LEAF_W(3)) u1 (.en(en1), .addr(addr1), .dec_out(out1));

  // {en, addr, expected set index; 64 means no line high}
  localparam logic [13:0] VEC [16] = '{
    {1'b1, 6'd0,  7'd0},  {1'b1, 6'd7,  7'd7},  {1'b1, 6'd8,  7'd8},  {1'b1, 6'd63, 7'd63},
    {1'b1, 6'd56, 7'd56}, {1'b1, 6'd9,  7'd9},  {1'b1, 6'd42, 7'd42}, {1'b1, 6'd21, 7'd21},
    {1'b0, 6'd0,  7'd64}, {1'b0, 6'd63, 7'd64}, {1'b0, 6'd42, 7'd64}, {1'b1, 6'd15, 7'd15},
    {1'b1, 6'd48, 7'd48}, {1'b1, 6'd55, 7'd55}, {1'b0, 6'd8,  7'd64}, {1'b1, 6'd31, 7'd31}
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive0(input logic e, input logic [5:0] a);
    @(negedge clk);
    en0 = e;
    addr0 = a;
    #1;
  endtask

  initial begin
    #1;
    check(out0 == '0, "R3 initial idle", out0, '0);
    for (int i = 0; i < 16; i++) begin
      logic [63:0] exp;
      int gi;
      drive0(VEC[i][13], VEC[i][12:7]);
      exp = (VEC[i][6:0] == 7'd64) ? 64'd0 : (64'd1 << VEC[i][6:0]);
      check(out0 == exp, VEC[i][13] ? "R1 table vector" : "R3 table vector", out0, exp);
      gi = int'(VEC[i][12:10]);
      check((out0[gi*8 +: 8] != 8'd0) == VEC[i][13] && (out0 & ~(64'hFF << (gi*8))) == '0,
            "R4 group select", out0, exp);
    end
    for (int e = 0; e < 2; e++) begin
      for (int a = 0; a < 64; a++) begin
        logic [63:0] exp;
        drive0(e[0], a[5:0]);
        exp = 64'(e) << a;
        check(out0 == exp, "R5 exhaustive shift law", out0, exp);
        check($countones(out0) == e, "R2 one-hot count", out0, exp);
      end
    end
    for (int e = 0; e < 2; e++) begin
      for (int a = 0; a < 16; a++) begin
        logic [15:0] exp;
        @(negedge clk);
        en1 = e[0];
        addr1 = a[3:0];
        #1;
        exp = 16'(e) << a;
        check(out1 == exp, "R6 4-to-16 tree", 64'(out1), 64'(exp));
        check((out1[15:8] != 8'd0) == (e == 1 && a >= 8), "R6 upper cell select", 64'(out1), 64'(exp));
      end
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule